// File: doc/BRIEF.md
# Per-Core Power Sequencing Controller

This block sequences power for a cluster of up to four processor cores. Software reaches it through a small 32-bit register bus. Setting a bit in the wake register powers a standby core up. The bit stays set until the power-up has finished, so software polls until the register reads zero. Writing 3 to a core's control register arms standby for that core. The arm has no effect until the core next asserts its wait-for-interrupt input. At that point the core is powered down, and its control value clears once standby is reached.

Each core has a power-enable output and a reset output, and these follow a per-core state machine. Power-up and power-down are each modelled as a fixed-latency handshake of `SEQ_CYCLES` cycles. A packed status register shows every core's state at any moment. A debug reset register only stores a set of enable bits.

Top module: `core_power_seq`

## Requirements
- R1: After reset, core 0 is running, with powerEn high and coreReset low. Every other core is in standby, with powerEn low and coreReset high. Status (offset 0x40) reads 3 in the field of each standby core and 0 elsewhere. The wake register, the control registers and the debug register all read 0.
- R2: Writing a 1 to bit n of the wake register (offset 0x10) while core n is in standby has these effects. Wake bit n reads 1 from the next cycle. The status field of core n reads 1 (powering up) for `SEQ_CYCLES` cycles, with powerEn high and coreReset high. After that the field reads 0 (running), coreReset goes low and wake bit n reads 0. Several cores can be woken by one write.
- R3: A wake bit written for a core that is already running reads 0 in the cycle after the write, and the core's status does not change.
- R4: The control register of core n is at offset 0x100 + 0x10·n and reads back the low 2 bits written. Writing 3 arms standby but leaves the core running until its wfiIn is asserted.
- R5: With its control value at 3, a running core that asserts wfiIn has status 2 (powering down) for `SEQ_CYCLES` cycles, with powerEn high and coreReset high. Its status then becomes 3, powerEn goes low and its control register reads 0.
- R6: wfiIn is ignored when the core's control value is not 3.
- R7: coreReset is high whenever powerEn is low, and coreReset is low only while the core is running.
- R8: The debug register (offset 0x180) keeps only bit 24, bit 19 and bits 20+n for each present core n. All other bits read 0.
- R9: Core n's status is the 2-bit field at bits 4n+1:4n, and every other status bit reads 0. Reads from unmapped offsets return 0, and writes to unmapped offsets change nothing.
- R10: A wake written while a core is powering down stays pending, and wake bit n reads 1 meanwhile. Once the core reaches standby, it powers up on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from busAddr |
| wfiIn | input | NUM_CORES | Per-core wait-for-interrupt indication |
| powerEn | output | NUM_CORES | Per-core power switch enable |
| coreReset | output | NUM_CORES | Per-core reset, active high |

## Verification
Reads are combinational, so a register's value is due in the same cycle as its address. A write or wfiIn pulse sampled on edge t shows its first effect (wake bit set, or status 1 or 2) just after edge t. The final state (running or standby) appears just after edge t + SEQ_CYCLES. The bench drives and samples at falling edges and steps through every cycle of each transition, checking the intermediate status in each one and the final status exactly on the expected cycle. For a wake that is pending during a power-down, the bench expects standby after the remaining down cycles, status 1 one cycle later, and running SEQ_CYCLES cycles after that.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int MAX_CORES = 4;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_UP   = 2'd1,
    PS_DOWN = 2'd2,
    PS_STBY = 2'd3
  } pwrState_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_WAKE,
    RD_STATUS,
    RD_CTL,
    RD_DBG
  } rdSel_e;

  typedef struct packed {
    logic                 wakeWr;
    logic [MAX_CORES-1:0] ctlWr;
    logic                 dbgWr;
    rdSel_e               rdSel;
    logic [1:0]           rdCore;
  } strobe_t;
endpackage

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CORES = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobe
);
  localparam logic [ADDR_W-1:0] WAKE_OFS   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] CTL_BASE   = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] DBG_OFS    = ADDR_W'('h180);

  logic       isCtl;
  logic [1:0] coreIdx;

  always_comb begin
    coreIdx = busAddr[5:4];
    isCtl   = (busAddr[ADDR_W-1:6] == CTL_BASE[ADDR_W-1:6]) &&
              (busAddr[3:0] == 4'd0) && (32'(coreIdx) < NUM_CORES);
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.rdCore = coreIdx;
    if (busAddr == WAKE_OFS) begin
      strobe.rdSel  = RD_WAKE;
      strobe.wakeWr = busWe;
    end else if (busAddr == STATUS_OFS) begin
      strobe.rdSel = RD_STATUS;
    end else if (busAddr == DBG_OFS) begin
      strobe.rdSel = RD_DBG;
      strobe.dbgWr = busWe;
    end else if (isCtl) begin
      strobe.rdSel          = RD_CTL;
      strobe.ctlWr[coreIdx] = busWe;
    end
  end
endmodule

// File: rtl/cps_core_fsm.sv
module cps_core_fsm
  import cps_pkg::*;
#(
  parameter int SEQ_CYCLES = 8,
  parameter bit START_RUN  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wakeHit,
  input  logic       ctlWr,
  input  logic [1:0] ctlData,
  input  logic       wfi,
  output pwrState_e  state,
  output logic       wakePend,
  output logic [1:0] ctlVal,
  output logic       powerEn,
  output logic       coreRst
);
  localparam int              CNT_W    = (SEQ_CYCLES > 1) ? $clog2(SEQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SEQ_CYCLES - 1);
  localparam logic [1:0]       ARM_CODE = 2'd3;

  pwrState_e        nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             seqDone, armed;

  assign seqDone = (cnt == '0);
  assign armed   = (ctlVal == ARM_CODE);
  assign powerEn = (state != PS_STBY);
  assign coreRst = (state != PS_RUN);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    case (state)
      PS_RUN:  if (armed && wfi) begin
                 nextState = PS_DOWN;
                 nextCnt   = CNT_LOAD;
               end
      PS_UP:   if (seqDone) nextState = PS_RUN;
               else nextCnt = cnt - 1'b1;
      PS_DOWN: if (seqDone) nextState = PS_STBY;
               else nextCnt = cnt - 1'b1;
      PS_STBY: if (wakePend || wakeHit) begin
                 nextState = PS_UP;
                 nextCnt   = CNT_LOAD;
               end
      default: nextState = PS_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= START_RUN ? PS_RUN : PS_STBY;
      cnt      <= '0;
      wakePend <= 1'b0;
      ctlVal   <= 2'd0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      if (state == PS_UP && seqDone) wakePend <= 1'b0;
      else if (wakeHit && state != PS_RUN) wakePend <= 1'b1;
      if (state == PS_DOWN && seqDone) ctlVal <= 2'd0;
      else if (ctlWr) ctlVal <= ctlData;
    end
  end
endmodule

// File: rtl/cps_datapath.sv
module cps_datapath
  import cps_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int SEQ_CYCLES = 8,
  parameter int DATA_W     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                strobe,
  input  logic [DATA_W-1:0]      busWdata,
  input  logic [NUM_CORES-1:0]   wfiIn,
  output logic [DATA_W-1:0]      busRdata,
  output logic [NUM_CORES-1:0]   powerEn,
  output logic [NUM_CORES-1:0]   coreReset,
  output logic [4*NUM_CORES-1:0] statusWord
);
  localparam logic [DATA_W-1:0] DBG_MASK =
      (DATA_W'(1) << 24) | (DATA_W'(1) << 19) |
      (DATA_W'((1 << NUM_CORES) - 1) << 20);

  pwrState_e              coreState [NUM_CORES];
  logic [1:0]             ctlVals   [NUM_CORES];
  logic [NUM_CORES-1:0]   wakeVec;
  logic [DATA_W-1:0]      dbgReg;

  for (genvar g = 0; g < NUM_CORES; g++) begin : gCore
    cps_core_fsm #(
      .SEQ_CYCLES(SEQ_CYCLES),
      .START_RUN (1'(g == 0))
    ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .wakeHit (strobe.wakeWr && busWdata[g]),
      .ctlWr   (strobe.ctlWr[g]),
      .ctlData (busWdata[1:0]),
      .wfi     (wfiIn[g]),
      .state   (coreState[g]),
      .wakePend(wakeVec[g]),
      .ctlVal  (ctlVals[g]),
      .powerEn (powerEn[g]),
      .coreRst (coreReset[g])
    );
    assign statusWord[4*g +: 4] = {2'b00, coreState[g]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbgReg <= '0;
    else if (strobe.dbgWr) dbgReg <= busWdata & DBG_MASK;
  end

  always_comb begin
    busRdata = '0;
    case (strobe.rdSel)
      RD_WAKE:   busRdata = DATA_W'(wakeVec);
      RD_STATUS: busRdata = DATA_W'(statusWord);
      RD_CTL:    busRdata = DATA_W'(ctlVals[strobe.rdCore]);
      RD_DBG:    busRdata = dbgReg;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/core_power_seq.sv
module core_power_seq
  import cps_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int SEQ_CYCLES = 8,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_CORES-1:0] wfiIn,
  output logic [NUM_CORES-1:0] powerEn,
  output logic [NUM_CORES-1:0] coreReset
);
  strobe_t                strobe;
  logic [4*NUM_CORES-1:0] statusWord;

  cps_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_CORES(NUM_CORES)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  cps_datapath #(
    .NUM_CORES (NUM_CORES),
    .SEQ_CYCLES(SEQ_CYCLES),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .wfiIn     (wfiIn),
    .busRdata  (busRdata),
    .powerEn   (powerEn),
    .coreReset (coreReset),
    .statusWord(statusWord)
  );
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CORES-1:0]   powerEn,
  input logic [NUM_CORES-1:0]   coreReset,
  input logic [4*NUM_CORES-1:0] statusWord
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : gChk
    AST_UNPOWERED_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !powerEn[i] |-> coreReset[i]); // R7
    AST_RUN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (statusWord[4*i +: 2] == 2'd0) |-> (powerEn[i] && !coreReset[i])); // R2
    AST_STBY_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (statusWord[4*i +: 2] == 2'd3) |-> (!powerEn[i] && coreReset[i])); // R5
    AST_WAKE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(statusWord[4*i +: 2]) == 2'd3 && statusWord[4*i +: 2] != 2'd3)
        |-> statusWord[4*i +: 2] == 2'd1); // R10
    AST_SLEEP_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(statusWord[4*i +: 2]) == 2'd0 && statusWord[4*i +: 2] != 2'd0)
        |-> statusWord[4*i +: 2] == 2'd2); // R5
  end
endmodule

bind core_power_seq cps_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .powerEn   (powerEn),
  .coreReset (coreReset),
  .statusWord(statusWord)
);

// File: tb/sim_core_power_seq.sv
module sim_core_power_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NC         = 4;
  localparam int SEQ        = 8;
  localparam int WD_LIMIT   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   busAddr = '0;
  logic          busWe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NC-1:0] wfiIn = '0;
  logic [NC-1:0] powerEn, coreReset;

  int errors = 0;
  int checks = 0;
  int expState [NC];
  int cycles = 0;
  bit done = 1'b0;

  core_power_seq #(.NUM_CORES(NC), .SEQ_CYCLES(SEQ), .ADDR_W(12), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .wfiIn(wfiIn),
    .powerEn(powerEn), .coreReset(coreReset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] packStatus();
    logic [31:0] v = '0;
    for (int n = 0; n < NC; n++) v |= 32'(expState[n]) << (4 * n);
    return v;
  endfunction

  function automatic logic [NC-1:0] expPower();
    logic [NC-1:0] v;
    for (int n = 0; n < NC; n++) v[n] = (expState[n] != 3);
    return v;
  endfunction

  function automatic logic [NC-1:0] expReset();
    logic [NC-1:0] v;
    for (int n = 0; n < NC; n++) v[n] = (expState[n] != 0);
    return v;
  endfunction

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic pulseWfi(input int c);
    wfiIn[c] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wfiIn[c] = 1'b0;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d;
    rd(12'h040, d);
    chk(req, d, packStatus());
    chk(req, 32'(powerEn), 32'(expPower()));
    chk(req, 32'(coreReset), 32'(expReset()));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int n = 0; n < NC; n++) expState[n] = (n == 0) ? 0 : 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkAll("R1");
    rd(12'h010, d); chk("R1 wake", d, 0);
    rd(12'h180, d); chk("R1 dbg", d, 0);
    for (int n = 0; n < NC; n++) begin
      rd(12'(12'h100 + 16 * n), d); chk("R1 ctl", d, 0);
    end

    // R9 unmapped read and write
    rd(12'h044, d); chk("R9 unmapped read", d, 0);
    wr(12'h044, 32'hFFFF_FFFF);
    checkAll("R9 unmapped write");
    rd(12'h104, d); chk("R9 unmapped ctl gap", d, 0);

    // R2 wake each standby core
    for (int c = 1; c < NC; c++) begin
      wr(12'h010, 32'(1) << c);
      expState[c] = 1;
      rd(12'h010, d); chk("R2 wake pending", d, 32'(1) << c);
      checkAll("R2 powering up");
      for (int k = 1; k < SEQ; k++) begin
        @(negedge clk);
        checkAll("R2 up hold");
      end
      @(negedge clk);
      expState[c] = 0;
      checkAll("R2 running");
      rd(12'h010, d); chk("R2 wake cleared", d, 0);
    end

    // R3 wake on running core
    wr(12'h010, 32'h1);
    rd(12'h010, d); chk("R3 wake clear", d, 0);
    checkAll("R3 no change");

    // R6, R4, R5 per core
    for (int c = 0; c < NC; c++) begin
      wr(12'(12'h100 + 16 * c), 32'h1);
      rd(12'(12'h100 + 16 * c), d); chk("R4 ctl readback", d, 1);
      pulseWfi(c);
      checkAll("R6 wfi ignored");
      wr(12'(12'h100 + 16 * c), 32'h3);
      rd(12'(12'h100 + 16 * c), d); chk("R4 armed readback", d, 3);
      repeat (3) @(negedge clk);
      checkAll("R4 no immediate effect");
      pulseWfi(c);
      expState[c] = 2;
      checkAll("R5 powering down");
      for (int k = 1; k < SEQ; k++) begin
        @(negedge clk);
        checkAll("R5 down hold");
      end
      @(negedge clk);
      expState[c] = 3;
      checkAll("R5 standby");
      rd(12'(12'h100 + 16 * c), d); chk("R5 ctl cleared", d, 0);
    end

    // R2 simultaneous wake of all cores
    wr(12'h010, 32'hF);
    for (int n = 0; n < NC; n++) expState[n] = 1;
    rd(12'h010, d); chk("R2 multi pending", d, 32'hF);
    for (int k = 1; k < SEQ; k++) @(negedge clk);
    checkAll("R2 multi up");
    @(negedge clk);
    for (int n = 0; n < NC; n++) expState[n] = 0;
    checkAll("R2 multi running");
    rd(12'h010, d); chk("R2 multi cleared", d, 0);

    // R10 wake during power-down of core 2
    wr(12'h120, 32'h3);
    pulseWfi(2);
    expState[2] = 2;
    checkAll("R10 down");
    wr(12'h010, 32'h4);
    rd(12'h010, d); chk("R10 pending", d, 32'h4);
    for (int k = 0; k < SEQ - 2; k++) @(negedge clk);
    checkAll("R10 still down");
    @(negedge clk);
    expState[2] = 3;
    checkAll("R10 standby");
    rd(12'h010, d); chk("R10 pending held", d, 32'h4);
    @(negedge clk);
    expState[2] = 1;
    checkAll("R10 powering up");
    for (int k = 0; k < SEQ; k++) @(negedge clk);
    expState[2] = 0;
    checkAll("R10 running");
    rd(12'h010, d); chk("R10 wake cleared", d, 0);

    // R8 debug register masking
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, d); chk("R8 mask all", d, (32'(1) << 24) | (32'(1) << 19) | (32'((1 << NC) - 1) << 20));
    wr(12'h180, 32'h0010_0000);
    rd(12'h180, d); chk("R8 single", d, 32'h0010_0000);
    wr(12'h180, 32'hFE07_FFFF);
    rd(12'h180, d); chk("R8 none kept", d, 0);
    checkAll("R9 status after debug");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule